// File: doc/BRIEF.md
# Serial Flash Hold and Write-Protect Front End

This block sits at the pin side of a serial flash slave. It samples the chip select, serial clock, serial data in, pause and write-protect pins with the system clock. From those samples it decides when a transfer is paused, and when it may resume.

While a transfer is paused, the serial output driver is disabled. Clock edges and data bits are ignored, and the bit position inside the current byte is kept. Received bytes are assembled most significant bit first. The first byte of each select period is flagged as the opcode.

When that opcode is the status-write command (0x01), the block decides whether the command may run. The decision uses the write-protect pin and the lock-down bit of the status register. It reports the result as a one-cycle grant pulse or a one-cycle refusal pulse. A quad-enable flag gives both pins over to data duty, and that switches off both the pause function and the write-protect function.

Top module: `sflash_hold_guard`

## Requirements
- R1: After reset, with cs_n high, so_oe and hold_active are 0, and rx_valid, wrsr_grant and wrsr_reject stay 0.
- R2: With cs_n low and quad_en 0, a low hold_n sampled while sck is low puts the block in hold (hold_active=1). If hold_n goes low while sck is high, hold begins only once sck is next sampled low.
- R3: Hold ends when hold_n is sampled high while sck is low. If hold_n rises while sck is high, hold persists until sck is next sampled low.
- R4: While in hold, so_oe is 0, and sck and si transitions are ignored. After hold ends, the byte continues from the same bit position.
- R5: cs_n high clears hold and discards any partial byte. After cs_n returns low, hold is re-entered if hold_n is still low, so resuming needs hold_n high and cs_n low.
- R6: With quad_en=1, hold_n has no effect (hold_active stays 0 and bytes are received), and the write-protect pin does not block the status write.
- R7: Bytes are shifted in on sck rising edges, MSB first. After each eighth edge, rx_valid pulses for one clock with rx_byte. rx_first is 1 only for the first byte after cs_n falls.
- R8: A first byte of 0x01 gives exactly one wrsr_reject pulse when wp_n is low, status_lock (status register bit 7) is 1 and quad_en is 0. In every other combination it gives exactly one wrsr_grant pulse. The status write is never both granted and refused.
- R9: A first byte other than 0x01, or a 0x01 that is not the first byte, produces neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than sck |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select pin, active low |
| sck | input | 1 | Serial clock pin |
| si | input | 1 | Serial data in pin |
| hold_n | input | 1 | Pause pin, active low |
| wp_n | input | 1 | Write-protect pin, active low |
| quad_en | input | 1 | Quad mode flag from status register |
| status_lock | input | 1 | Status register bit 7, lock-down |
| so_oe | output | 1 | Serial output driver enable |
| hold_active | output | 1 | Transfer is paused |
| rx_byte | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle strobe for rx_byte |
| rx_first | output | 1 | rx_byte is the opcode of the frame |
| wrsr_grant | output | 1 | Status write allowed, one-cycle pulse |
| wrsr_reject | output | 1 | Status write refused, one-cycle pulse |

## Verification
A hold flag stuck set or cleared shows at so_oe and hold_active within four system clocks of the sampled pin change. It shows later as a missing or extra byte strobe. A bit counter that moves during hold, or that survives a deselect, shows up at the next rx_valid as a rotated or shifted rx_byte. A fault in the write gate shows as a pulse on the wrong output, or as no pulse, one system clock after the opcode's strobe. The bench sweeps all eight combinations of wp_n, status_lock and quad_en.

// File: rtl/sfg_pkg.sv
// Shared types for the serial flash hold/protect front end.
// Assumes: all pins are sampled as one packed group.
package sfg_pkg;
    typedef struct packed {
        logic cs_n;
        logic sck;
        logic si;
        logic hold_n;
        logic wp_n;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, si: 1'b0, hold_n: 1'b1, wp_n: 1'b1};
    localparam int PIN_COUNT = $bits(pins_t);
endpackage

// File: rtl/sfg_sync.sv
// Pin sampler: delays the pin group through STAGES flops of the system clock.
// Assumes: STAGES >= 1 and sck is slow enough that every level lasts at least
// STAGES+1 system clocks.
module sfg_sync
    import sfg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  pins_t pins_in,
    output pins_t pins_out
);
    pins_t stage_q [STAGES];

    // Shift the pin samples one stage per clock; reset to idle levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= PINS_IDLE;
        end else begin
            stage_q[0] <= pins_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign pins_out = stage_q[STAGES-1];
endmodule

// File: rtl/sfg_hold_fsm.sv
// Hold tracker: decides whether the transfer is paused.
// Entry and exit are only allowed while the sampled clock is low, so a
// pause request seen during a clock-high phase waits for the next low phase.
// Assumes sampled inputs from sfg_sync.
module sfg_hold_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_s,
    input  logic sck_s,
    input  logic hold_n_s,
    input  logic quad_en,
    output logic in_hold
);
    // Follow the pause pin during clock-low phases; deselect or quad clears it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_hold <= 1'b0;
        end else if (cs_n_s || quad_en) begin
            in_hold <= 1'b0;
        end else if (!sck_s) begin
            in_hold <= !hold_n_s;
        end
    end

    // R2: hold may only start after a clock-low sample
    a_r2_enter_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_hold) |-> $past(!sck_s));
    // R3: hold may only end on a clock-low sample, deselect or quad mode
    a_r3_exit_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_hold) |-> $past(!sck_s || cs_n_s || quad_en));
    // R6: quad mode never leaves the block paused
    a_r6_quad_no_hold: assert property (@(posedge clk) disable iff (!rst_n)
        quad_en |=> !in_hold);
endmodule

// File: rtl/sfg_shifter.sv
// Byte assembler: shifts si in on sampled sck rising edges, MSB first.
// It freezes while paused and restarts its bit count whenever deselected.
// Assumes cs_n falls while sck is low.
module sfg_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sck_s,
    input  logic              si_s,
    input  logic              in_hold,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_first
);
    localparam int CNT_W = (WORD_W > 2) ? $clog2(WORD_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic              sck_q;
    logic [CNT_W-1:0]  cnt;
    logic [WORD_W-1:0] shreg;
    logic              first_pending;
    logic              rise;
    logic [WORD_W-1:0] shreg_next;

    assign rise       = sck_s && !sck_q && !cs_n_s && !in_hold;
    assign shreg_next = {shreg[WORD_W-2:0], si_s};

    // Remember the previous clock sample for edge detection, also during hold.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_q <= 1'b0;
        else        sck_q <= sck_s;
    end

    // Count bits, assemble bytes and raise the byte strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt           <= '0;
            shreg         <= '0;
            rx_byte       <= '0;
            rx_valid      <= 1'b0;
            rx_first      <= 1'b0;
            first_pending <= 1'b1;
        end else begin
            rx_valid <= 1'b0;
            if (cs_n_s) begin
                cnt           <= '0;
                first_pending <= 1'b1;
            end else if (rise) begin
                shreg <= shreg_next;
                if (cnt == LAST) begin
                    cnt           <= '0;
                    rx_valid      <= 1'b1;
                    rx_byte       <= shreg_next;
                    rx_first      <= first_pending;
                    first_pending <= 1'b0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R4: the bit position is frozen while paused
    a_r4_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hold && !cs_n_s) |=> $stable(cnt));
    // R5: deselect restarts the bit count
    a_r5_deselect_clears: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> (cnt == '0));
    // R7: the byte strobe is a single-cycle pulse
    a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);
endmodule

// File: rtl/sfg_wrsr_gate.sv
// Status-write gate: on an opcode byte equal to WRSR_OP it raises a grant
// or a refusal pulse one clock later. A refusal needs the protect pin low and
// the lock-down bit set, outside quad mode.
module sfg_wrsr_gate #(
    parameter int              WORD_W  = 8,
    parameter logic [WORD_W-1:0] WRSR_OP = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] rx_byte,
    input  logic              rx_valid,
    input  logic              rx_first,
    input  logic              wp_n_s,
    input  logic              quad_en,
    input  logic              status_lock,
    output logic              wrsr_grant,
    output logic              wrsr_reject
);
    logic is_wrsr;
    logic locked;

    assign is_wrsr = rx_valid && rx_first && (rx_byte == WRSR_OP);
    assign locked  = !quad_en && !wp_n_s && status_lock;

    // Register the verdict as single-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wrsr_grant  <= 1'b0;
            wrsr_reject <= 1'b0;
        end else begin
            wrsr_grant  <= is_wrsr && !locked;
            wrsr_reject <= is_wrsr && locked;
        end
    end

    // R8: never both verdicts at once
    a_r8_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wrsr_grant, wrsr_reject}));
    // R8: a refusal follows a locked pin and bit combination
    a_r8_reject_cause: assert property (@(posedge clk) disable iff (!rst_n)
        wrsr_reject |-> $past(!wp_n_s && status_lock && !quad_en));
    // R9: any verdict follows a status-write opcode strobe
    a_r9_needs_opcode: assert property (@(posedge clk) disable iff (!rst_n)
        (wrsr_grant || wrsr_reject) |-> $past(rx_valid && rx_first && rx_byte == WRSR_OP));
endmodule

// File: rtl/sflash_hold_guard.sv
// Top of the serial flash hold and write-protect front end.
// Pins pass through a sampler. A hold tracker, a byte assembler and a
// status-write gate then work on the sampled values.
// Assumes sck is slow relative to clk.
module sflash_hold_guard
    import sfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int WORD_W      = 8,
    parameter logic [WORD_W-1:0] WRSR_OP = 8'h01
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sck,
    input  logic              si,
    input  logic              hold_n,
    input  logic              wp_n,
    input  logic              quad_en,
    input  logic              status_lock,
    output logic              so_oe,
    output logic              hold_active,
    output logic [WORD_W-1:0] rx_byte,
    output logic              rx_valid,
    output logic              rx_first,
    output logic              wrsr_grant,
    output logic              wrsr_reject
);
    pins_t pins_raw;
    pins_t pins_s;
    logic  in_hold;

    assign pins_raw = '{cs_n: cs_n, sck: sck, si: si, hold_n: hold_n, wp_n: wp_n};

    sfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins_in  (pins_raw),
        .pins_out (pins_s)
    );

    sfg_hold_fsm u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s.cs_n),
        .sck_s    (pins_s.sck),
        .hold_n_s (pins_s.hold_n),
        .quad_en  (quad_en),
        .in_hold  (in_hold)
    );

    sfg_shifter #(.WORD_W(WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_s   (pins_s.cs_n),
        .sck_s    (pins_s.sck),
        .si_s     (pins_s.si),
        .in_hold  (in_hold),
        .rx_byte  (rx_byte),
        .rx_valid (rx_valid),
        .rx_first (rx_first)
    );

    sfg_wrsr_gate #(.WORD_W(WORD_W), .WRSR_OP(WRSR_OP)) u_gate (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_byte     (rx_byte),
        .rx_valid    (rx_valid),
        .rx_first    (rx_first),
        .wp_n_s      (pins_s.wp_n),
        .quad_en     (quad_en),
        .status_lock (status_lock),
        .wrsr_grant  (wrsr_grant),
        .wrsr_reject (wrsr_reject)
    );

    assign so_oe       = !pins_s.cs_n && !in_hold;
    assign hold_active = in_hold;

    // R1: no strobe while the sampled select is high
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pins_s.cs_n) |-> !rx_valid);
endmodule

// File: tb/sflash_hold_guard_bench.sv
module sflash_hold_guard_bench;
    localparam int PH = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, si = 1'b0, hold_n = 1'b1, wp_n = 1'b1;
    logic quad_en = 1'b0, status_lock = 1'b0;
    logic so_oe, hold_active, rx_valid, rx_first, wrsr_grant, wrsr_reject;
    logic [7:0] rx_byte;

    int checks = 0, errors = 0;
    int n_bytes = 0, n_grant = 0, n_reject = 0;
    logic [7:0] last_byte = '0;
    logic last_first = 1'b0;
    bit done = 0;

    always #4 clk = ~clk;

    sflash_hold_guard u_sflash_hold_guard (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
        .hold_n(hold_n), .wp_n(wp_n), .quad_en(quad_en), .status_lock(status_lock),
        .so_oe(so_oe), .hold_active(hold_active), .rx_byte(rx_byte),
        .rx_valid(rx_valid), .rx_first(rx_first),
        .wrsr_grant(wrsr_grant), .wrsr_reject(wrsr_reject)
    );

    // Count strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                n_bytes++;
                last_byte  = rx_byte;
                last_first = rx_first;
            end
            if (wrsr_grant)  n_grant++;
            if (wrsr_reject) n_reject++;
        end
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sck = 1'b0; si = b; tick(PH);
        sck = 1'b1; tick(PH);
    endtask

    task automatic send_byte(input logic [7:0] v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        sck = 1'b0; tick(PH);
    endtask

    task automatic start_frame();
        cs_n = 1'b1; sck = 1'b0; tick(PH);
        cs_n = 1'b0; tick(PH);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int nb;
        tick(4);
        rst_n = 1'b1;
        tick(PH);
        // R1 reset state
        check(so_oe, 0, "R1 so_oe");
        check(hold_active, 0, "R1 hold_active");
        check(n_bytes + n_grant + n_reject, 0, "R1 pulses");

        // R7 plain bytes, opcode flag
        start_frame();
        check(so_oe, 1, "R7 so_oe selected");
        send_byte(8'hA5);
        check(n_bytes, 1, "R7 count"); check(last_byte, 8'hA5, "R7 byte0"); check(last_first, 1, "R7 first");
        send_byte(8'h3C);
        check(last_byte, 8'h3C, "R7 byte1"); check(last_first, 0, "R7 not first");

        // R2/R3/R4 hold at clock-low, garbage ignored, position kept
        start_frame();
        nb = n_bytes;
        for (int i = 7; i >= 5; i--) send_bit(8'h96 >> i);
        sck = 1'b0; tick(PH);
        hold_n = 1'b0; tick(PH);
        check(hold_active, 1, "R2 enter low");
        check(so_oe, 0, "R4 so_oe off");
        for (int k = 0; k < 4; k++) begin
            si = k[0]; sck = 1'b1; tick(PH); sck = 1'b0; tick(PH);
        end
        check(n_bytes, nb, "R4 no strobe in hold");
        hold_n = 1'b1; tick(PH);
        check(hold_active, 0, "R3 exit low");
        for (int i = 4; i >= 0; i--) send_bit(8'h96 >> i);
        sck = 1'b0; tick(PH);
        check(last_byte, 8'h96, "R4 byte resumed");

        // R2/R3 deferred entry and exit while clock high
        start_frame();
        for (int i = 7; i >= 4; i--) send_bit(8'hC3 >> i);
        hold_n = 1'b0; tick(PH);
        check(hold_active, 0, "R2 deferred");
        sck = 1'b0; tick(PH);
        check(hold_active, 1, "R2 entered later");
        sck = 1'b1; si = 1'b0; tick(PH);
        hold_n = 1'b1; tick(PH);
        check(hold_active, 1, "R3 deferred");
        sck = 1'b0; tick(PH);
        check(hold_active, 0, "R3 exited later");
        for (int i = 3; i >= 0; i--) send_bit(8'hC3 >> i);
        sck = 1'b0; tick(PH);
        check(last_byte, 8'hC3, "R4 byte after deferral");

        // R5 deselect during hold
        start_frame();
        for (int i = 0; i < 4; i++) send_bit(1'b1);
        sck = 1'b0; tick(PH);
        hold_n = 1'b0; tick(PH);
        check(hold_active, 1, "R5 in hold");
        cs_n = 1'b1; tick(PH);
        check(hold_active, 0, "R5 cleared");
        cs_n = 1'b0; tick(PH);
        check(hold_active, 1, "R5 needs hold_n high");
        hold_n = 1'b1; tick(PH);
        send_byte(8'h5A);
        check(last_byte, 8'h5A, "R5 partial discarded"); check(last_first, 1, "R5 opcode again");

        // R6 quad mode ignores hold_n
        quad_en = 1'b1;
        start_frame();
        nb = n_bytes;
        send_bit(1'b0); send_bit(1'b1);
        sck = 1'b0; hold_n = 1'b0; tick(PH);
        check(hold_active, 0, "R6 no hold");
        check(so_oe, 1, "R6 so_oe");
        for (int i = 5; i >= 0; i--) send_bit(8'h69 >> i);
        sck = 1'b0; tick(PH);
        check(n_bytes, nb + 1, "R6 strobe"); check(last_byte, 8'h69, "R6 byte");
        hold_n = 1'b1; quad_en = 1'b0; tick(PH);

        // R8/R6 sweep of all pin and bit combinations, R9 repeat opcode
        for (int c = 0; c < 8; c++) begin
            int g0, r0, lk;
            quad_en = c[2]; wp_n = c[1]; status_lock = c[0];
            lk = (!c[2] && !c[1] && c[0]) ? 1 : 0;
            g0 = n_grant; r0 = n_reject;
            start_frame();
            send_byte(8'h01); tick(PH);
            check(n_reject - r0, lk, "R8 reject");
            check(n_grant - g0, 1 - lk, "R8 grant");
            send_byte(8'h01); tick(PH);
            check(n_grant + n_reject - g0 - r0, 1, "R9 non-first 01");
        end

        // R9 other opcode while locked
        quad_en = 1'b0; wp_n = 1'b0; status_lock = 1'b1;
        begin
            int t0;
            t0 = n_grant + n_reject;
            start_frame(); send_byte(8'h81); tick(PH);
            check(n_grant + n_reject, t0, "R9 other opcode");
            start_frame(); send_byte(8'h02); tick(PH);
            check(n_grant + n_reject, t0, "R9 other opcode 2");
        end
        cs_n = 1'b1; tick(PH);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule